// File: doc/BRIEF.md
# Edge/Level Interrupt Request Controller

This block collects interrupt requests from two sources, an external request pin and a serial-receive event, and presents them to a processor. The pin can be watched in one of two detection modes. In edge mode a low-to-high transition is stored in a request flag. In level mode the stored flag is bypassed and the pending request is simply the present pin level. A small write-only register interface selects the detection mode and clears pending pin requests by code. The receive request is different: it stays pending until the receive buffer is read, and software writes have no effect on it.

The processor takes an interrupt in two steps. It first accepts it with `ack_i`, then reads the vector with `vec_rd_i`. The vector is chosen at the read, not at the accept. If the request has gone away in between, the fixed default vector 0x0008 is returned. A global enable gates the request line to the processor. A wake output reports any pending request whatever the enable, so it can release a halted core.

Top module: `irq_edge_level_ctrl`

## Requirements
- R1: In edge mode (mode register bit 0 = 0, the reset value), a low-to-high transition of the synchronized pin sets the pin request flag, and the flag stays set after the pin falls.
- R2: In level mode (mode register bit 0 = 1), the pin request is pending exactly while the synchronized pin is high, and `wake_o` follows it.
- R3: A mode write that selects level mode while the block is in edge mode clears the pin request flag.
- R4: A mode write that selects edge mode while the block is in level mode keeps the flag as it stood in level mode. A high pin at that moment leaves a request pending until it is cleared.
- R5: A write to the clear register (`reg_addr_i` = 1) with data 0x0A clears the pin request flag in edge mode. Any other data value leaves the flag unchanged.
- R6: A pulse on `rx_req_i` sets the receive request flag. Only a pulse on `rx_buf_rd_i` or a reset clears it. Clear-register writes and vector reads leave it set.
- R7: At a vector read, a pending pin request wins over a pending receive request. They return `PIN_VEC` and `RX_VEC`.
- R8: A vector read with no request pending returns the default vector 0x0008.
- R9: A vector read that returns the pin vector in edge mode clears the pin request flag.
- R10: `irq_o` is high only while `irq_en_i` is high and some request is pending. Lowering the enable does not change the stored flags.
- R11: `wake_o` is high while any request is pending, independent of `irq_en_i`.
- R12: A vector read is honoured only after an `ack_i` since the last honoured read. It updates `vec_o` and raises `vec_vld_o` for exactly one cycle after the read. A read without a prior accept changes neither.
- R13: After reset, `irq_o`, `wake_o` and `vec_vld_o` are low, both flags are clear and `vec_o` holds 0x0008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| rx_req_i | input | 1 | Receive-complete request pulse |
| rx_buf_rd_i | input | 1 | Receive buffer read pulse, clears the receive request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 mode, 1 clear |
| reg_wdata_i | input | 8 | Register write data |
| irq_en_i | input | 1 | Global enable for the request line |
| ack_i | input | 1 | Processor has accepted the interrupt |
| vec_rd_i | input | 1 | Processor vector read cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | Halt release, high while any request is pending |
| vec_o | output | VEC_W | Vector from the last honoured read |
| vec_vld_o | output | 1 | One-cycle strobe after an honoured read |

## Verification
The bench builds the block with two pin synchronizer stages and 16-bit vectors. It sets the pin vector to 0x0010 and the receive vector to 0x0018, so all three possible vector values differ from one another. With two stages, a pin change reaches the flag after a fixed and known number of cycles. The table steps through both mode switches with the pin high and low, and through both sources pending at once. It also withdraws a level request between accept and vector read.

// File: rtl/irq_pkg.sv
// Shared types and constants for the edge/level interrupt controller.
// Assumes a one-bit register select and byte-wide write data.
package irq_pkg;

    // Which source a vector read selected.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PIN  = 2'd1,
        SRC_RX   = 2'd2
    } irq_src_e;

    localparam logic REG_MODE = 1'b0;
    localparam logic REG_CLR  = 1'b1;
    localparam int   REG_DW   = 8;

endpackage

// File: rtl/irq_pin_sync.sv
// Brings the asynchronous pin into the clock domain through STAGES flops.
// Assumes STAGES = 0 only when the pin is already synchronous.
module irq_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic pin_s_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign pin_s_o = pin_i;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;

            // Shift the pin through the synchronizer chain.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    sh_q <= '0;
                end else begin
                    sh_q[0] <= pin_i;
                    for (int k = 1; k < STAGES; k++) begin
                        sh_q[k] <= sh_q[k-1];
                    end
                end
            end

            assign pin_s_o = sh_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/irq_pin_src.sv
// Pin request source: holds the detection mode bit and the request flag.
// Edge mode latches rising edges. Level mode bypasses the flag for the
// pending output while the flag shadows the pin. Assumes pin_s_i is
// synchronous.
module irq_pin_src (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_s_i,
    input  logic mode_wr_i,
    input  logic mode_lvl_i,
    input  logic clr_hit_i,
    input  logic ack_clr_i,
    output logic level_o,
    output logic flag_o,
    output logic pend_o
);

    logic level_q;
    logic flag_q;
    logic pin_d_q;
    logic rise;
    logic to_level;

    assign rise     = pin_s_i && !pin_d_q;
    assign to_level = mode_wr_i && mode_lvl_i && !level_q;

    // Mode register and previous pin sample for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            level_q <= 1'b0;
            pin_d_q <= 1'b0;
        end else begin
            pin_d_q <= pin_s_i;
            if (mode_wr_i) begin
                level_q <= mode_lvl_i;
            end
        end
    end

    // Request flag: mode-switch clear, level shadow, edge set, then clears.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (to_level) begin
            flag_q <= 1'b0;
        end else if (level_q) begin
            flag_q <= pin_s_i;
        end else if (rise) begin
            flag_q <= 1'b1;
        end else if (clr_hit_i || ack_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign level_o = level_q;
    assign flag_o  = flag_q;
    assign pend_o  = level_q ? pin_s_i : flag_q;

endmodule

// File: rtl/irq_rx_src.sv
// Receive request source: set by a receive pulse, cleared only by a buffer
// read or reset. A set and a read in the same cycle leave it set.
module irq_rx_src (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic buf_rd_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the receive request until the buffer is read.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (buf_rd_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/irq_vec_sel.sv
// Accept/vector-read handshake and fixed-priority vector choice.
// The vector is chosen at the read cycle from the requests pending then.
// Assumes ack_i and vec_rd_i are single-cycle pulses from the processor.
module irq_vec_sel
    import irq_pkg::*;
#(
    parameter int unsigned          VEC_W   = 16,
    parameter logic [VEC_W-1:0]     PIN_VEC = 16'h0028,
    parameter logic [VEC_W-1:0]     RX_VEC  = 16'h0030,
    parameter logic [VEC_W-1:0]     DEF_VEC = 16'h0008
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_pend_i,
    input  logic             rx_pend_i,
    input  logic             ack_i,
    input  logic             vec_rd_i,
    output logic             busy_o,
    output logic             pin_taken_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vld_o
);

    irq_src_e         src;
    logic [VEC_W-1:0] sel_vec;
    logic             busy_q;
    logic             vld_q;
    logic [VEC_W-1:0] vec_q;
    logic             take;

    // Fixed priority: pin first, then receive, else the default.
    always_comb begin
        if (pin_pend_i) begin
            src     = SRC_PIN;
            sel_vec = PIN_VEC;
        end else if (rx_pend_i) begin
            src     = SRC_RX;
            sel_vec = RX_VEC;
        end else begin
            src     = SRC_NONE;
            sel_vec = DEF_VEC;
        end
    end

    assign take        = vec_rd_i && busy_q;
    assign pin_taken_o = take && (src == SRC_PIN);

    // Track accept, capture the vector on an honoured read.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_q <= 1'b0;
            vld_q  <= 1'b0;
            vec_q  <= DEF_VEC;
        end else if (take) begin
            busy_q <= 1'b0;
            vld_q  <= 1'b1;
            vec_q  <= sel_vec;
        end else begin
            vld_q <= 1'b0;
            if (ack_i) begin
                busy_q <= 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign vec_o  = vec_q;
    assign vld_o  = vld_q;

endmodule

// File: rtl/irq_edge_level_ctrl.sv
// Top of the edge/level interrupt request controller: register decode,
// the two request sources, vector handshake and the processor-facing lines.
// Assumes the register strobe is a single-cycle pulse.
module irq_edge_level_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned           SYNC_STAGES = 2,
    parameter int unsigned           VEC_W       = 16,
    parameter logic [REG_DW-1:0]     PIN_CLR_CODE = 8'h0A,
    parameter logic [VEC_W-1:0]      PIN_VEC     = 16'h0028,
    parameter logic [VEC_W-1:0]      RX_VEC      = 16'h0030,
    parameter logic [VEC_W-1:0]      DEF_VEC     = 16'h0008
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_i,
    input  logic             rx_req_i,
    input  logic             rx_buf_rd_i,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    input  logic             irq_en_i,
    input  logic             ack_i,
    input  logic             vec_rd_i,
    output logic             irq_o,
    output logic             wake_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_vld_o
);

    logic pin_s;
    logic mode_wr;
    logic clr_hit;
    logic level_q;
    logic pin_flag;
    logic pin_pend;
    logic rx_flag;
    logic busy;
    logic pin_taken;
    logic any_pend;

    // Register decode: mode select and pin clear code.
    assign mode_wr = reg_wr_i && (reg_addr_i == REG_MODE);
    assign clr_hit = reg_wr_i && (reg_addr_i == REG_CLR) && (reg_wdata_i == PIN_CLR_CODE);

    irq_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .pin_s_o (pin_s)
    );

    irq_pin_src pin_src_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_s_i    (pin_s),
        .mode_wr_i  (mode_wr),
        .mode_lvl_i (reg_wdata_i[0]),
        .clr_hit_i  (clr_hit),
        .ack_clr_i  (pin_taken),
        .level_o    (level_q),
        .flag_o     (pin_flag),
        .pend_o     (pin_pend)
    );

    irq_rx_src rx_src_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (rx_req_i),
        .buf_rd_i (rx_buf_rd_i),
        .flag_o   (rx_flag)
    );

    irq_vec_sel #(
        .VEC_W   (VEC_W),
        .PIN_VEC (PIN_VEC),
        .RX_VEC  (RX_VEC),
        .DEF_VEC (DEF_VEC)
    ) vec_sel_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pin_pend_i  (pin_pend),
        .rx_pend_i   (rx_flag),
        .ack_i       (ack_i),
        .vec_rd_i    (vec_rd_i),
        .busy_o      (busy),
        .pin_taken_o (pin_taken),
        .vec_o       (vec_o),
        .vld_o       (vec_vld_o)
    );

    // Processor-facing lines: gated request and ungated wake.
    assign any_pend = pin_pend || rx_flag;
    assign irq_o    = irq_en_i && any_pend;
    assign wake_o   = any_pend;

endmodule

// File: rtl/irq_ctrl_chk.sv
// Checker for irq_edge_level_ctrl, attached through bind below.
module irq_ctrl_chk #(
    parameter int unsigned      VEC_W   = 16,
    parameter logic [VEC_W-1:0] PIN_VEC = 16'h0028,
    parameter logic [VEC_W-1:0] DEF_VEC = 16'h0008
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             rx_buf_rd,
    input logic             vec_rd,
    input logic             irq,
    input logic             wake,
    input logic             vld,
    input logic [VEC_W-1:0] vec,
    input logic             busy,
    input logic             level_q,
    input logic             pin_flag,
    input logic             pin_s,
    input logic             pin_pend,
    input logic             rx_flag
);

    AST_EDGE_TO_LEVEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata[0] && !level_q) |=> !pin_flag); // R3

    AST_LEVEL_TO_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && !reg_wdata[0] && level_q && pin_s) |=> pin_flag); // R4

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !rx_buf_rd) |=> rx_flag); // R6

    AST_PIN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && busy && pin_pend) |=> (vec == PIN_VEC)); // R7

    AST_DEFAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && busy && !wake) |=> (vec == DEF_VEC)); // R8

    AST_IRQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wake); // R10

    AST_VLD_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(vec_rd)); // R12

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld); // R12

endmodule

bind irq_edge_level_ctrl irq_ctrl_chk #(
    .VEC_W   (VEC_W),
    .PIN_VEC (PIN_VEC),
    .DEF_VEC (DEF_VEC)
) chk_i (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .reg_wr    (reg_wr_i),
    .reg_addr  (reg_addr_i),
    .reg_wdata (reg_wdata_i),
    .rx_buf_rd (rx_buf_rd_i),
    .vec_rd    (vec_rd_i),
    .irq       (irq_o),
    .wake      (wake_o),
    .vld       (vec_vld_o),
    .vec       (vec_o),
    .busy      (busy),
    .level_q   (level_q),
    .pin_flag  (pin_flag),
    .pin_s     (pin_s),
    .pin_pend  (pin_pend),
    .rx_flag   (rx_flag)
);

// File: tb/irq_edge_level_ctrl_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module irq_edge_level_ctrl_tb_top;

    localparam logic [15:0] PV = 16'h0010;
    localparam logic [15:0] RV = 16'h0018;
    localparam logic [15:0] DV = 16'h0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic        rxs = 1'b0;
    logic        rxr = 1'b0;
    logic        wr = 1'b0;
    logic        addr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic        en = 1'b0;
    logic        ack = 1'b0;
    logic        vrd = 1'b0;
    logic        irq;
    logic        wake;
    logic [15:0] vec;
    logic        vld;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_edge_level_ctrl #(
        .SYNC_STAGES (2),
        .VEC_W       (16),
        .PIN_VEC     (PV),
        .RX_VEC      (RV),
        .DEF_VEC     (DV)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pin),
        .rx_req_i    (rxs),
        .rx_buf_rd_i (rxr),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .irq_en_i    (en),
        .ack_i       (ack),
        .vec_rd_i    (vrd),
        .irq_o       (irq),
        .wake_o      (wake),
        .vec_o       (vec),
        .vec_vld_o   (vld)
    );

    // {pin,rxs,rxr,wr,addr,wdata,en,ack,vrd, exp_irq,exp_wake,exp_vec}
    localparam int NV = 34;
    localparam logic [33:0] TBL [NV] = '{
        {5'b00000, 8'h00, 3'b100, 2'b00, 16'h0008}, // R13 idle
        {5'b10000, 8'h00, 3'b100, 2'b11, 16'h0008}, // R1 rise
        {5'b00000, 8'h00, 3'b100, 2'b11, 16'h0008}, // R1 held after fall
        {5'b00000, 8'h00, 3'b000, 2'b01, 16'h0008}, // R10 R11 enable low
        {5'b00000, 8'h00, 3'b100, 2'b11, 16'h0008}, // R10 flag kept
        {5'b00000, 8'h00, 3'b110, 2'b11, 16'h0008}, // R12 accept
        {5'b00000, 8'h00, 3'b101, 2'b00, 16'h0010}, // R9 pin vector, flag cleared
        {5'b01000, 8'h00, 3'b100, 2'b11, 16'h0010}, // R6 rx set
        {5'b00011, 8'h0A, 3'b100, 2'b11, 16'h0010}, // R6 clear write ignored
        {5'b10000, 8'h00, 3'b110, 2'b11, 16'h0010}, // R7 both pending
        {5'b10000, 8'h00, 3'b101, 2'b11, 16'h0010}, // R7 pin first
        {5'b00000, 8'h00, 3'b110, 2'b11, 16'h0010}, // R6 accept
        {5'b00000, 8'h00, 3'b101, 2'b11, 16'h0018}, // R6 R7 rx vector, flag kept
        {5'b00100, 8'h00, 3'b100, 2'b00, 16'h0018}, // R6 buffer read clears
        {5'b10000, 8'h00, 3'b100, 2'b11, 16'h0018}, // R1 rise
        {5'b10011, 8'h0A, 3'b100, 2'b00, 16'h0018}, // R5 clear code
        {5'b10010, 8'h01, 3'b100, 2'b11, 16'h0018}, // R2 level, pin high
        {5'b00000, 8'h00, 3'b100, 2'b00, 16'h0018}, // R2 follows low
        {5'b10000, 8'h00, 3'b100, 2'b11, 16'h0018}, // R2 follows high
        {5'b10010, 8'h00, 3'b100, 2'b11, 16'h0018}, // R4 to edge, kept
        {5'b00000, 8'h00, 3'b100, 2'b11, 16'h0018}, // R4 still pending
        {5'b00011, 8'h0A, 3'b100, 2'b00, 16'h0018}, // R5 software clear
        {5'b10000, 8'h00, 3'b100, 2'b11, 16'h0018}, // R1 rise
        {5'b00000, 8'h00, 3'b100, 2'b11, 16'h0018}, // R1 held
        {5'b00010, 8'h01, 3'b100, 2'b00, 16'h0018}, // R3 to level clears
        {5'b00010, 8'h00, 3'b100, 2'b00, 16'h0018}, // R4 back to edge, nothing
        {5'b10010, 8'h01, 3'b100, 2'b11, 16'h0018}, // R2 level high
        {5'b10000, 8'h00, 3'b110, 2'b11, 16'h0018}, // R12 accept
        {5'b00000, 8'h00, 3'b100, 2'b00, 16'h0018}, // R8 withdrawn
        {5'b00000, 8'h00, 3'b101, 2'b00, 16'h0008}, // R8 default vector
        {5'b00010, 8'h00, 3'b100, 2'b00, 16'h0008}, // R4 to edge, pin low
        {5'b10000, 8'h00, 3'b100, 2'b11, 16'h0008}, // R1 rise
        {5'b10011, 8'h0B, 3'b100, 2'b11, 16'h0008}, // R5 wrong code
        {5'b10011, 8'h0A, 3'b100, 2'b00, 16'h0008}  // R5 right code
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_pulses();
        rxs = 1'b0; rxr = 1'b0; wr = 1'b0; ack = 1'b0; vrd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R13 irq", {15'd0, irq}, 16'd0);
        chk("R13 wake", {15'd0, wake}, 16'd0);
        chk("R13 vld", {15'd0, vld}, 16'd0);
        chk("R13 vec", vec, DV);
        @(posedge clk); #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(posedge clk); #1;
            {pin, rxs, rxr, wr, addr, wdata, en, ack, vrd} = TBL[i][33:18];
            @(posedge clk); #1;
            clear_pulses();
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk($sformatf("row %0d irq R10", i), {15'd0, irq}, {15'd0, TBL[i][17]});
            chk($sformatf("row %0d wake R11", i), {15'd0, wake}, {15'd0, TBL[i][16]});
            chk($sformatf("row %0d vec R7", i), vec, TBL[i][15:0]);
        end

        // R12: one-cycle strobe after an accepted read (receive vector).
        @(posedge clk); #1 rxs = 1'b1;
        @(posedge clk); #1 rxs = 1'b0; ack = 1'b1;
        @(posedge clk); #1 ack = 1'b0; vrd = 1'b1;
        @(negedge clk);
        chk("R12 no strobe before read edge", {15'd0, vld}, 16'd0);
        @(posedge clk); #1 vrd = 1'b0;
        @(negedge clk);
        chk("R12 strobe", {15'd0, vld}, 16'd1);
        chk("R12 vec", vec, RV);
        @(negedge clk);
        chk("R12 strobe one cycle", {15'd0, vld}, 16'd0);

        // R12 R9: a read without accept leaves vector and pin flag alone.
        @(posedge clk); #1 pin = 1'b0; rxr = 1'b1;
        @(posedge clk); #1 rxr = 1'b0;
        repeat (3) @(posedge clk);
        #1 pin = 1'b1;
        repeat (4) @(posedge clk);
        #1 vrd = 1'b1;
        @(posedge clk); #1 vrd = 1'b0;
        @(negedge clk);
        chk("R12 unaccepted read strobe", {15'd0, vld}, 16'd0);
        chk("R12 unaccepted read vec", vec, RV);
        chk("R9 flag kept", {15'd0, irq}, 16'd1);

        // R13 R6: reset mid-run clears everything.
        @(posedge clk); #1 rxs = 1'b1; rst_n = 1'b0;
        @(posedge clk); #1 rxs = 1'b0;
        @(negedge clk);
        chk("R13 irq after reset", {15'd0, irq}, 16'd0);
        chk("R6 wake after reset", {15'd0, wake}, 16'd0);
        chk("R13 vec after reset", vec, DV);
        chk("R13 vld after reset", {15'd0, vld}, 16'd0);

        finish_run();
    end

endmodule